// File: doc/BRIEF.md
# Look-Ahead Pipelined First-Order IIR Filter

This block realises the single-pole recursion y(n) = a·y(n−1) + u(n), but rearranged so that the feedback path only needs the output from three samples back. A feed-forward section first forms v(n) = u(n) + a·u(n−1) + a²·u(n−2). A recursive section then forms y(n) = a³·y(n−3) + v(n). Because the loop now spans three delays, its multiply, scale and add each get their own register. The clock period is therefore set by one of those steps rather than by a complete multiply-add. For the same coefficient, the transfer function matches the original one-pole filter apart from fixed-point quantisation.

The host writes the pole coefficient a while no samples are moving. The block then derives a² and a³ and holds them. After that, one sample may be offered on any clock. Every stage advances only on clocks that carry a sample, so idle cycles do not disturb the recursion. The result for a sample comes out on the clock after the sample three positions later in the stream has been accepted.

Top module: `lookahead_iir`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears `out_valid`, `out_sample`, the coefficient, its derived powers, the input delay line and every loop register to zero.
- R2: A clock edge with `coef_load` high stores `coef_in` as a. a is a signed fixed-point value with CW−2 fraction bits, so the integer 2^(CW−2) means 1.0, and |a| ≤ 1 is assumed. The derived values are a2 = floor(a·a / 2^(CW−2)) and a3 = floor(a2·a / 2^(CW−2)), each clamped to CW bits. They are stable from the third clock after the load. Samples may start at that point.
- R3: For each accepted sample, v(n) = u(n) + floor(a·u(n−1)/2^(CW−2)) + floor(a2·u(n−2)/2^(CW−2)). Inputs from before the first sample after reset count as zero. The sum is kept at full width.
- R4: y(n) = sat(floor(a3·y(n−3)/2^(CW−2)) + v(n)). Here sat clamps to DW+GW signed bits, and y(n−3) counts as zero for n < 3.
- R5: `out_valid` is high in the cycle after the edge that accepts sample k, provided k ≥ 3 (counting from 0 after reset), and is low otherwise. In that cycle `out_sample` equals y(k−3) clamped to DW signed bits.
- R6: A clock with `in_valid` low changes no filter state and leaves `out_sample` unchanged. `out_valid` is low in the following cycle.
- R7: With |a| ≤ 0.75 and no clamping, `out_sample` stays within 10 LSB of the exact real-valued recursion y(n) = a·y(n−1) + u(n).
- R8: Samples offered on consecutive clocks are all accepted. A stream of N back-to-back samples yields exactly N−3 valid outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| coef_load | input | 1 | Store `coef_in` as the pole coefficient |
| coef_in | input | CW | Signed pole coefficient, CW−2 fraction bits |
| in_valid | input | 1 | `in_sample` carries a sample this clock |
| in_sample | input | DW | Signed input sample u(n) |
| out_valid | output | 1 | `out_sample` carries a new result |
| out_sample | output | DW | Signed filtered sample, clamped |

## Verification
A unit impulse is swept across the whole coefficient range, stepped finely, so that the three-sample loop structure shows directly. A wrong tap, a wrong power or a wrong loop distance puts energy in the wrong output slot. Pseudo-random full-scale input, with idle cycles inserted at regular points, separates correct freezing on idle clocks from a pipeline that keeps running. Constant and alternating full-scale inputs at a = ±1.0 drive the guard bits into clamping in both directions. A second sweep over moderate coefficients compares against the exact real-valued recursion, which exposes any error in the look-ahead algebra that a matching bit-accurate model would share.

// File: rtl/iir_pkg.sv
package iir_pkg;
  // Order of the look-ahead: number of delays inside the feedback loop.
  localparam int LA = 3;
  // Sign bit plus one integer bit, so a coefficient of exactly 1.0 fits.
  localparam int COEF_INT_BITS = 2;
endpackage

// File: rtl/iir_sat.sv
module iir_sat #(
  parameter int IW = 16,
  parameter int OW = 8
) (
  input  logic signed [IW-1:0] din,
  output logic signed [OW-1:0] dout
);
  if (IW > OW) begin : g_clip
    logic [IW-OW:0] top_bits;
    logic           ovf;
    assign top_bits = din[IW-1:OW-1];
    assign ovf      = !((&top_bits) || !(|top_bits));
    assign dout     = ovf ? {din[IW-1], {(OW-1){~din[IW-1]}}} : din[OW-1:0];
  end else if (IW == OW) begin : g_pass
    assign dout = din;
  end else begin : g_ext
    assign dout = OW'(din);
  end
endmodule

// File: rtl/iir_coef.sv
module iir_coef import iir_pkg::*; #(
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic signed [CW-1:0] coef_in,
  output logic signed [CW-1:0] tap_pow [1:LA-1],
  output logic signed [CW-1:0] loop_pow
);
  localparam int F  = CW - COEF_INT_BITS;
  localparam int PW = 2 * CW;

  logic signed [CW-1:0] pow_q [1:LA];
  logic signed [CW-1:0] pow_n [2:LA];

  // Each power is the previous one times a, rescaled and clamped.
  for (genvar k = 2; k <= LA; k++) begin : g_pow
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] prod_sh;
    assign prod    = pow_q[k-1] * pow_q[1];
    assign prod_sh = prod >>> F;
    iir_sat #(.IW(PW), .OW(CW)) u_clip (.din(prod_sh), .dout(pow_n[k]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 1; k <= LA; k++) pow_q[k] <= '0;
    end else begin
      if (load) pow_q[1] <= coef_in;
      for (int k = 2; k <= LA; k++) pow_q[k] <= pow_n[k];
    end
  end

  always_comb begin
    for (int k = 1; k < LA; k++) tap_pow[k] = pow_q[k];
    loop_pow = pow_q[LA];
  end
endmodule

// File: rtl/iir_feedfwd.sv
module iir_feedfwd import iir_pkg::*; #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int VW = 34
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] u_in,
  input  logic signed [CW-1:0] tap_pow [1:LA-1],
  output logic signed [VW-1:0] v_q
);
  localparam int F  = CW - COEF_INT_BITS;
  localparam int PW = DW + CW;

  logic signed [DW-1:0] dl   [1:LA-1];
  logic signed [PW-1:0] prod [1:LA-1];
  logic signed [DW-1:0] cur_q;
  logic signed [VW-1:0] v_n;

  // Stage 1: capture the sample and the scaled older samples.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 1; k < LA; k++) begin
        dl[k]   <= '0;
        prod[k] <= '0;
      end
      cur_q <= '0;
      v_q   <= '0;
    end else if (en) begin
      dl[1] <= u_in;
      for (int k = 2; k < LA; k++) dl[k] <= dl[k-1];
      for (int k = 1; k < LA; k++) prod[k] <= tap_pow[k] * dl[k];
      cur_q <= u_in;
      v_q   <= v_n;
    end
  end

  // Stage 2: full-width sum of the numerator terms.
  always_comb begin
    v_n = VW'(cur_q);
    for (int k = 1; k < LA; k++) v_n = v_n + VW'(prod[k] >>> F);
  end
endmodule

// File: rtl/iir_loop.sv
module iir_loop import iir_pkg::*; #(
  parameter int YW = 20,
  parameter int CW = 16,
  parameter int VW = 34
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [CW-1:0] loop_pow,
  input  logic signed [VW-1:0] v_in,
  output logic signed [YW-1:0] y_q
);
  localparam int F  = CW - COEF_INT_BITS;
  localparam int MW = YW + CW;
  localparam int SW = ((MW > VW) ? MW : VW) + 1;

  logic signed [MW-1:0] mul_q;
  logic signed [MW-1:0] scl_q;
  logic signed [SW-1:0] sum;
  logic signed [YW-1:0] y_n;

  assign sum = SW'(scl_q) + SW'(v_in);

  iir_sat #(.IW(SW), .OW(YW)) u_clip (.din(sum), .dout(y_n));

  // Three registers around the loop: multiply, rescale, add.
  always_ff @(posedge clk) begin
    if (rst) begin
      mul_q <= '0;
      scl_q <= '0;
      y_q   <= '0;
    end else if (en) begin
      mul_q <= loop_pow * y_q;
      scl_q <= mul_q >>> F;
      y_q   <= y_n;
    end
  end
endmodule

// File: rtl/lookahead_iir.sv
module lookahead_iir import iir_pkg::*; #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int GW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 coef_load,
  input  logic signed [CW-1:0] coef_in,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_sample
);
  localparam int YW = DW + GW;
  localparam int VW = DW + CW + $clog2(LA);
  localparam int FW = $clog2(LA + 1);

  logic signed [CW-1:0] tap_pow [1:LA-1];
  logic signed [CW-1:0] loop_pow;
  logic signed [CW-1:0] coef_a;
  logic signed [VW-1:0] v_sum;
  logic signed [YW-1:0] y_loop;
  logic signed [DW-1:0] y_clip;
  logic [FW-1:0]        fill_q;
  logic                 full;

  iir_coef #(.CW(CW)) u_coef (
    .clk(clk), .rst(rst), .load(coef_load), .coef_in(coef_in),
    .tap_pow(tap_pow), .loop_pow(loop_pow)
  );

  iir_feedfwd #(.DW(DW), .CW(CW), .VW(VW)) u_ff (
    .clk(clk), .rst(rst), .en(in_valid), .u_in(in_sample),
    .tap_pow(tap_pow), .v_q(v_sum)
  );

  iir_loop #(.YW(YW), .CW(CW), .VW(VW)) u_loop (
    .clk(clk), .rst(rst), .en(in_valid), .loop_pow(loop_pow),
    .v_in(v_sum), .y_q(y_loop)
  );

  iir_sat #(.IW(YW), .OW(DW)) u_out_clip (.din(y_loop), .dout(y_clip));

  assign coef_a = tap_pow[1];
  assign full   = (fill_q == FW'(LA));

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q     <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid && full;
      if (in_valid) begin
        out_sample <= y_clip;
        if (!full) fill_q <= fill_q + FW'(1);
      end
    end
  end
endmodule

// File: rtl/lookahead_iir_chk.sv
module lookahead_iir_chk import iir_pkg::*; #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int YW = 20
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 coef_load,
  input logic signed [CW-1:0] coef_in,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_sample,
  input logic signed [CW-1:0] coef_a,
  input logic signed [YW-1:0] y_loop
);
  localparam int SCW = $clog2(LA + 2);

  logic [SCW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (in_valid && seen != SCW'(LA + 1)) seen <= seen + SCW'(1);
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_sample == '0));

  assert_coef_capture_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(coef_load) && !$past(rst)) |-> (coef_a == $past(coef_in)));

  assert_valid_needs_fill_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(in_valid) && seen == SCW'(LA + 1)));

  assert_valid_when_full_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && !$past(rst) && $past(seen) >= SCW'(LA)) |-> out_valid);

  assert_idle_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_valid) && !$past(rst)) |-> ($stable(y_loop) && $stable(out_sample)));
endmodule

bind lookahead_iir lookahead_iir_chk #(.DW(DW), .CW(CW), .YW(YW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .coef_load(coef_load),
  .coef_in(coef_in), .out_valid(out_valid), .out_sample(out_sample),
  .coef_a(coef_a), .y_loop(y_loop)
);

// File: tb/lookahead_iir_test.sv
module lookahead_iir_test;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int GW = 4;
  localparam int FB = CW - 2;
  localparam int YW = DW + GW;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 coef_load = 1'b0;
  logic signed [CW-1:0] coef_in = '0;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_sample = '0;
  logic                 out_valid;
  logic signed [DW-1:0] out_sample;

  lookahead_iir #(.DW(DW), .CW(CW), .GW(GW)) uut (
    .clk(clk), .rst(rst), .coef_load(coef_load), .coef_in(coef_in),
    .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  always #10 clk = ~clk;

  int  checks = 0;
  int  errors = 0;
  int  acc_cnt = 0;
  int  out_cnt = 0;
  int  last_out = 0;
  bit  acc_prev = 1'b0;
  bit  active = 1'b0;
  bit  dir_mode = 1'b0;
  int  exp_o [0:127];
  int  y_h   [0:127];
  int  u_h   [0:127];
  real dir_o [0:127];
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int sat_i(input int v, input int w);
    int lim;
    lim = 1 << (w - 1);
    if (v > lim - 1) return lim - 1;
    if (v < -lim) return -lim;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      acc_cnt  = 0;
      acc_prev = 1'b0;
    end else begin
      acc_prev = in_valid;
      if (in_valid) acc_cnt++;
    end
  end

  always @(negedge clk) begin
    if (active && !rst) begin
      bit  expv;
      int  o;
      real d;
      o    = int'(out_sample);
      expv = acc_prev && (acc_cnt >= 4);
      if (acc_prev) chk(out_valid == expv, "R5 valid", int'(out_valid), int'(expv));
      else          chk(out_valid == 1'b0, "R6 valid", int'(out_valid), 0);
      if (!acc_prev) chk(o == last_out, "R6 hold", o, last_out);
      if (out_valid && expv) begin
        chk(o == exp_o[out_cnt], "R2 R3 R4 sample", o, exp_o[out_cnt]);
        if (dir_mode) begin
          d = $itor(o) - dir_o[out_cnt];
          if (d < 0.0) d = -d;
          chk(d <= 10.0, "R7 direct", o, $rtoi(dir_o[out_cnt]));
        end
        out_cnt++;
      end
      last_out = o;
    end
  end

  task automatic run_case(input int a, input int pat, input int n, input bit gap, input bit dirm);
    int  a2m, a3m, u, u1, u2, y3, v;
    real ar;
    active = 1'b0;
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; coef_load = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    chk(out_sample == '0, "R1 sample", int'(out_sample), 0);
    coef_load = 1'b1;
    coef_in   = CW'(a);
    @(negedge clk);
    coef_load = 1'b0;
    repeat (4) @(negedge clk);
    a2m = sat_i((a * a) >>> FB, CW);
    a3m = sat_i((a2m * a) >>> FB, CW);
    ar  = $itor(a) / $itor(1 << FB);
    out_cnt  = 0;
    last_out = 0;
    dir_mode = dirm;
    active   = 1'b1;
    for (int k = 0; k < n; k++) begin
      case (pat)
        0: u = (k == 0) ? 20 : 0;
        1: begin lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]}; u = int'($signed(lf[7:0])); end
        2: u = 100;
        3: u = -100;
        4: u = (k % 2 == 0) ? 100 : -100;
        default: begin lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]}; u = int'(lf[4:0]) - 15; end
      endcase
      u_h[k] = u;
      u1 = (k >= 1) ? u_h[k-1] : 0;
      u2 = (k >= 2) ? u_h[k-2] : 0;
      y3 = (k >= 3) ? y_h[k-3] : 0;
      v  = u + ((a * u1) >>> FB) + ((a2m * u2) >>> FB);
      y_h[k]   = sat_i(((a3m * y3) >>> FB) + v, YW);
      exp_o[k] = sat_i(y_h[k], DW);
      dir_o[k] = ar * ((k >= 1) ? dir_o[k-1] : 0.0) + $itor(u);
      if (gap && (k % 3 == 2)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid  = 1'b1;
      in_sample = DW'(u);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    active = 1'b0;
    if (gap) chk(out_cnt == n - 3, "R5 count", out_cnt, n - 3);
    else     chk(out_cnt == n - 3, "R8 count", out_cnt, n - 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int a = -64; a <= 64; a += 8) run_case(a, 0, 24, 1'b0, 1'b0);
    for (int a = -64; a <= 64; a += 4) run_case(a, 1, 40, 1'b1, 1'b0);
    run_case(64, 2, 40, 1'b0, 1'b0);
    run_case(64, 3, 40, 1'b1, 1'b0);
    run_case(-64, 4, 40, 1'b0, 1'b0);
    run_case(32, 2, 30, 1'b0, 1'b0);
    for (int a = -48; a <= 48; a += 6) begin
      run_case(a, 0, 24, 1'b0, 1'b1);
      run_case(a, 5, 40, 1'b1, 1'b1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule